// File: doc/BRIEF.md
# Throttled-Burst SDRAM Controller

This block connects one user master to a single-rank SDRAM device. The master raises a request with a 32-bit byte address and a direction flag, and holds all three steady for the whole transfer. The controller opens the addressed row and then raises a per-beat ready. A data word moves on every clock where ready and the master's per-beat strobe are both high. The master may hold back the first beat, and it may pause at any later point. The transfer ends when the master drops its request. The controller then closes the row and pulses a completion flag.

Reads run as a stream of single-word READ commands issued ahead of the data, with CAS latency 2. A clock where ready is high but the master does not strobe throws away the words already requested. Ready then stays low while the controller re-requests data from the first word the master has not taken. Row ends are crossed inside a transfer: the controller closes the row, opens the next one and carries into the bank bits. A refresh that falls due is inserted while no transfer is running, or at a row change if it is already owed. After reset a fixed start-up command sequence runs before any ready can appear.

Top module: `sdram_ctl`

## Requirements
- R1: After reset, the non-NOP commands on the device pins are, in this order: precharge-all (A10 high), auto-refresh, auto-refresh, and mode-register load with A = 0x020 (burst length 1, CAS latency 2 in A[6:4]). No ACT, READ or WRITE appears, and beat_rdy stays low, until that load has been issued.
- R2: Commands are driven as {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACT 0011, READ 0101, WRITE 0100, PRE 0010, REF 0001, MRS 0000. The word address is req_addr[24:2]: column is [9:2], row is [22:10] and bank is [24:23]. During reset the pins show NOP.
- R3: beat_rdy is high only while req_active is high. A word moves only on a clock with beat_rdy and beat_go both high. Ready waits for the master for any number of clocks before the first beat.
- R4: Each write beat puts one WRITE on the next clock, carrying that beat's wr_data with sd_dq_oe high, to the next consecutive address. Clocks without a strobe are skipped, so no word is lost or duplicated.
- R5: On a read beat, rd_data holds the word at the next consecutive address. A ready clock without a strobe forces beat_rdy low on the following clock. Reading then resumes at the first word not yet taken.
- R6: A transfer that passes column 255 continues at column 0 of the next row, carrying into the bank bits. Between the two rows the controller issues a precharge and an activate, and beat_rdy stays low.
- R7: After req_active falls, cyc_done pulses high for exactly one clock once the row has been closed. It is never high while req_active is high.
- R8: A refresh is issued at least once every REF_INT clocks while the controller is idle, and only while all rows are closed.
- R9: Every ACT goes to a bank with no open row, and every READ and WRITE goes to a bank whose row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_active | input | 1 | Transfer request, held for the whole transfer |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_addr | input | 32 | Byte start address, held with the request |
| beat_go | input | 1 | Per-beat strobe from the master |
| wr_data | input | 32 | Write word for the current beat |
| beat_rdy | output | 1 | Controller can move a word this clock |
| rd_data | output | 32 | Read word, valid on a read beat |
| cyc_done | output | 1 | One-clock completion pulse |
| sd_cs_n | output | 1 | Device chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 13 | Row / column / mode address |
| sd_dq_out | output | 32 | Data driven toward the device |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 32 | Data returned by the device |

## Verification
Each transfer is run with three strobe patterns. A constant strobe shows the plain streaming rate. A pseudo-random strobe separates the write path's simple skip from the read path's discard-and-refill. A strobe on every fourth clock keeps interrupting the read pipeline, so read data survives only if the controller restarts at exactly the first word not taken. Start addresses are placed a few words before a row end, and once at the last row of a bank, so any fault in the column wrap or in the row or bank carry shows up as wrong read-back data. A held-back first strobe checks that ready waits. A long transfer and a long idle period bring in refresh both at a row change and between transfers.

// File: rtl/sdram_ctl_pkg.sv
// Shared types for the SDRAM controller: the pin-level command code and
// the sequencer state. Assumes a single-rank device with the usual
// {cs_n, ras_n, cas_n, we_n} command truth table.
package sdram_ctl_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_IREF1,
        ST_IREF2,
        ST_IMRS,
        ST_IDLE,
        ST_ACT,
        ST_RD,
        ST_WR,
        ST_PRE,
        ST_RREF,
        ST_DONE
    } ctl_st_e;

endpackage

// File: rtl/sdram_delay.sv
// Down-counter that enforces device timing gaps between commands.
// Loads a wait length, counts to zero, and reports idle at zero.
// Assumes a load is only requested while the counter is idle.
module sdram_delay #(
    parameter int W       = 16,
    parameter int RST_VAL = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         idle
);

    logic [W-1:0] cnt;

    // Count down after a load; the reset value gives the power-up wait.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= W'(RST_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign idle = (cnt == '0);

endmodule

// File: rtl/sdram_ref_timer.sv
// Refresh interval timer. Raises due every REF_INT clocks and holds it
// until the sequencer acknowledges. A new interval wins over a
// simultaneous acknowledge.
module sdram_ref_timer #(
    parameter int REF_INT = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);

    localparam int CW = $clog2(REF_INT + 1);

    logic [CW-1:0] cnt;

    // Free-running interval counter with a sticky due flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CW'(REF_INT - 1);
            due <= 1'b0;
        end else begin
            if (cnt == '0) begin
                cnt <= CW'(REF_INT - 1);
                due <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
                if (ack) due <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdram_rd_track.sv
// Tracks READ commands in flight. One stage per clock of device
// latency, so that the last stage lines up with the data on the bus.
// A flush drops every older entry but still accepts a new push.
module sdram_rd_track #(
    parameter int DEPTH = 3,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [CW-1:0] push_col,
    input  logic          flush,
    output logic          head_v,
    output logic [CW-1:0] head_col
);

    logic [DEPTH-1:0] vld;
    logic [CW-1:0]    col [DEPTH];

    // Shift the valid tags; a flush clears everything behind stage 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            vld[0] <= push;
            for (int i = 1; i < DEPTH; i++) vld[i] <= flush ? 1'b0 : vld[i-1];
        end
    end

    // Shift the column tags alongside the valid bits.
    always_ff @(posedge clk) begin
        col[0] <= push_col;
        for (int i = 1; i < DEPTH; i++) col[i] <= col[i-1];
    end

    assign head_v   = vld[DEPTH-1];
    assign head_col = col[DEPTH-1];

endmodule

// File: rtl/sdram_ctl.sv
// Single-master SDRAM controller with per-beat throttling.
// Runs the start-up sequence, opens a row per transfer, streams single
// word WRITEs or pipelined READs, and crosses row ends on its own.
// Refresh goes in between transfers or at a row change.
// Assumes: the master holds req_active/req_write/req_addr steady for the
// whole transfer; ROW_W > 10 (A10 selects precharge-all); COL_W <= 10.
module sdram_ctl
    import sdram_ctl_pkg::*;
#(
    parameter int DW       = 32,
    parameter int COL_W    = 8,
    parameter int ROW_W    = 13,
    parameter int BA_W     = 2,
    parameter int CAS_LAT  = 2,
    parameter int T_RP     = 2,
    parameter int T_RCD    = 2,
    parameter int T_RFC    = 7,
    parameter int T_MRD    = 2,
    parameter int T_WR     = 2,
    parameter int INIT_CYC = 100,
    parameter int REF_INT  = 1500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_active,
    input  logic            req_write,
    input  logic [31:0]     req_addr,
    input  logic            beat_go,
    input  logic [DW-1:0]   wr_data,
    output logic            beat_rdy,
    output logic [DW-1:0]   rd_data,
    output logic            cyc_done,
    output logic            sd_cs_n,
    output logic            sd_ras_n,
    output logic            sd_cas_n,
    output logic            sd_we_n,
    output logic [BA_W-1:0] sd_ba,
    output logic [ROW_W-1:0] sd_a,
    output logic [DW-1:0]   sd_dq_out,
    output logic            sd_dq_oe,
    input  logic [DW-1:0]   sd_dq_in
);

    localparam int RB_W   = ROW_W + BA_W;
    localparam int DLY_W  = 16;
    localparam int ADDR_LO = 2;
    localparam int ADDR_HI = ADDR_LO + COL_W + RB_W;
    localparam logic [COL_W-1:0] COL_MAX = '1;
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'((CAS_LAT & 7) << 4);

    ctl_st_e            st_q, st_n;
    sd_cmd_e            cmd_q, cmd_n;
    logic [ROW_W-1:0]   a_q, a_n;
    logic [BA_W-1:0]    ba_q, ba_n;
    logic [COL_W-1:0]   col_q, col_n;
    logic [RB_W-1:0]    rb_q, rb_n;
    logic               wr_q, wr_n;
    logic               end_q, end_n;
    logic               iss_end_q, iss_end_n;
    logic [DW-1:0]      dqo_q, dqo_n;
    logic               oe_q, oe_n;

    logic               dly_idle, dly_ld;
    logic [DLY_W-1:0]   dly_val;
    logic               ref_due, ref_ack;
    logic               rd_push, rd_flush, head_v;
    logic [COL_W-1:0]   head_col, iss_col;
    logic               do_iss;
    logic               addr_unused;

    assign addr_unused = ^{req_addr[31:ADDR_HI], req_addr[ADDR_LO-1:0]};

    sdram_delay #(.W(DLY_W), .RST_VAL(INIT_CYC)) u_dly (
        .clk(clk), .rst_n(rst_n), .load(dly_ld), .load_val(dly_val), .idle(dly_idle)
    );

    sdram_ref_timer #(.REF_INT(REF_INT)) u_ref (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .due(ref_due)
    );

    sdram_rd_track #(.DEPTH(CAS_LAT + 1), .CW(COL_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .push(rd_push), .push_col(iss_col),
        .flush(rd_flush), .head_v(head_v), .head_col(head_col)
    );

    // Ready: timing gap elapsed, request held, and a word can move now.
    assign beat_rdy = dly_idle && req_active &&
                      ((st_q == ST_WR) || (st_q == ST_RD && head_v));
    assign cyc_done = dly_idle && (st_q == ST_DONE);
    assign rd_data  = sd_dq_in;

    // Sequencer: picks the next command, state and timing gap.
    always_comb begin
        st_n      = st_q;
        cmd_n     = CMD_NOP;
        a_n       = a_q;
        ba_n      = ba_q;
        col_n     = col_q;
        rb_n      = rb_q;
        wr_n      = wr_q;
        end_n     = end_q;
        iss_end_n = iss_end_q;
        dqo_n     = dqo_q;
        oe_n      = 1'b0;
        dly_ld    = 1'b0;
        dly_val   = '0;
        ref_ack   = 1'b0;
        rd_push   = 1'b0;
        rd_flush  = 1'b0;
        do_iss    = 1'b0;
        iss_col   = col_q;
        if (dly_idle) begin
            unique case (st_q)
                ST_INIT: begin
                    cmd_n = CMD_PRE; a_n = '0; a_n[10] = 1'b1;
                    dly_ld = 1'b1; dly_val = DLY_W'(T_RP - 1); st_n = ST_IREF1;
                end
                ST_IREF1: begin
                    cmd_n = CMD_REF; dly_ld = 1'b1; dly_val = DLY_W'(T_RFC - 1);
                    st_n = ST_IREF2;
                end
                ST_IREF2: begin
                    cmd_n = CMD_REF; dly_ld = 1'b1; dly_val = DLY_W'(T_RFC - 1);
                    st_n = ST_IMRS;
                end
                ST_IMRS: begin
                    cmd_n = CMD_MRS; a_n = MODE_WORD; ba_n = '0;
                    dly_ld = 1'b1; dly_val = DLY_W'(T_MRD - 1); st_n = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_due) begin
                        cmd_n = CMD_REF; ref_ack = 1'b1;
                        dly_ld = 1'b1; dly_val = DLY_W'(T_RFC - 1);
                    end else if (req_active) begin
                        col_n = req_addr[ADDR_LO +: COL_W];
                        rb_n  = req_addr[ADDR_LO + COL_W +: RB_W];
                        wr_n  = req_write;
                        end_n = 1'b0;
                        st_n  = ST_ACT;
                    end
                end
                ST_ACT: begin
                    cmd_n = CMD_ACT;
                    a_n   = rb_q[ROW_W-1:0];
                    ba_n  = rb_q[RB_W-1:ROW_W];
                    dly_ld = 1'b1; dly_val = DLY_W'(T_RCD - 1);
                    iss_end_n = 1'b0;
                    st_n  = wr_q ? ST_WR : ST_RD;
                end
                ST_WR: begin
                    if (!req_active) begin
                        end_n = 1'b1; dly_ld = 1'b1; dly_val = DLY_W'(T_WR);
                        st_n = ST_PRE;
                    end else if (beat_go) begin
                        cmd_n = CMD_WR; a_n = '0; a_n[COL_W-1:0] = col_q;
                        dqo_n = wr_data; oe_n = 1'b1;
                        if (col_q == COL_MAX) begin
                            col_n = '0; rb_n = rb_q + 1'b1; end_n = 1'b0;
                            dly_ld = 1'b1; dly_val = DLY_W'(T_WR); st_n = ST_PRE;
                        end else begin
                            col_n = col_q + 1'b1;
                        end
                    end
                end
                ST_RD: begin
                    if (!req_active) begin
                        rd_flush = 1'b1; end_n = 1'b1; st_n = ST_PRE;
                    end else if (head_v && !beat_go) begin
                        rd_flush = 1'b1; iss_col = head_col; do_iss = 1'b1;
                    end else if (head_v && head_col == COL_MAX) begin
                        rd_flush = 1'b1; col_n = '0; rb_n = rb_q + 1'b1;
                        end_n = 1'b0; st_n = ST_PRE;
                    end else if (!iss_end_q) begin
                        do_iss = 1'b1;
                    end
                end
                ST_PRE: begin
                    cmd_n = CMD_PRE; a_n = '0; a_n[10] = 1'b1;
                    dly_ld = 1'b1; dly_val = DLY_W'(T_RP - 1);
                    if (end_q)        st_n = ST_DONE;
                    else if (ref_due) st_n = ST_RREF;
                    else              st_n = ST_ACT;
                end
                ST_RREF: begin
                    cmd_n = CMD_REF; ref_ack = 1'b1;
                    dly_ld = 1'b1; dly_val = DLY_W'(T_RFC - 1); st_n = ST_ACT;
                end
                ST_DONE: st_n = ST_IDLE;
                default: st_n = ST_INIT;
            endcase
        end
        if (do_iss) begin
            cmd_n   = CMD_RD;
            a_n     = '0;
            a_n[COL_W-1:0] = iss_col;
            rd_push = 1'b1;
            if (iss_col == COL_MAX) begin
                iss_end_n = 1'b1;
            end else begin
                iss_end_n = 1'b0;
                col_n     = iss_col + 1'b1;
            end
        end
    end

    // State and registered device pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_INIT;
            cmd_q     <= CMD_NOP;
            a_q       <= '0;
            ba_q      <= '0;
            col_q     <= '0;
            rb_q      <= '0;
            wr_q      <= 1'b0;
            end_q     <= 1'b0;
            iss_end_q <= 1'b0;
            dqo_q     <= '0;
            oe_q      <= 1'b0;
        end else begin
            st_q      <= st_n;
            cmd_q     <= cmd_n;
            a_q       <= a_n;
            ba_q      <= ba_n;
            col_q     <= col_n;
            rb_q      <= rb_n;
            wr_q      <= wr_n;
            end_q     <= end_n;
            iss_end_q <= iss_end_n;
            dqo_q     <= dqo_n;
            oe_q      <= oe_n;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_ba     = ba_q;
    assign sd_a      = a_q;
    assign sd_dq_out = dqo_q;
    assign sd_dq_oe  = oe_q;

endmodule

// File: rtl/sdram_ctl_chk.sv
// Protocol checker for sdram_ctl, attached by bind. It follows the row
// state and the start-up completion from the pins alone.
module sdram_ctl_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_active,
    input logic          req_write,
    input logic          beat_go,
    input logic [DW-1:0] wr_data,
    input logic          beat_rdy,
    input logic          cyc_done,
    input logic          sd_cs_n,
    input logic          sd_ras_n,
    input logic          sd_cas_n,
    input logic          sd_we_n,
    input logic [DW-1:0] sd_dq_out,
    input logic          sd_dq_oe
);

    logic [3:0] cmd;
    logic       init_ok, row_open;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // Follow the mode load and the open/closed row state seen on the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_ok  <= 1'b0;
            row_open <= 1'b0;
        end else begin
            if (cmd == 4'b0000) init_ok <= 1'b1;
            if (cmd == 4'b0011) row_open <= 1'b1;
            else if (cmd == 4'b0010) row_open <= 1'b0;
        end
    end

    AST_RDY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        beat_rdy |-> req_active);  // R3
    AST_ACCESS_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0011 || cmd == 4'b0101 || cmd == 4'b0100) |-> init_ok);  // R1
    AST_RDY_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        beat_rdy |-> init_ok);  // R1
    AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0011) |-> !row_open);  // R9
    AST_ACCESS_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0101 || cmd == 4'b0100) |-> row_open);  // R9
    AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0001) |-> !row_open);  // R8
    AST_WR_BEAT_TO_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_rdy && beat_go && req_write) |=>
            (cmd == 4'b0100 && sd_dq_oe && sd_dq_out == $past(wr_data)));  // R4
    AST_RD_SKIP_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_rdy && !beat_go && !req_write) |=> !beat_rdy);  // R5
    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);  // R7

endmodule

bind sdram_ctl sdram_ctl_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_active(req_active), .req_write(req_write),
    .beat_go(beat_go), .wr_data(wr_data), .beat_rdy(beat_rdy), .cyc_done(cyc_done),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe)
);

// File: tb/test_sdram_ctl.sv
`timescale 1ns/1ps
// Scoreboard bench: a behavioural device model, a driver task that
// queues the expected read words, and a monitor that compares them.
module test_sdram_ctl;

    localparam int REF_INT = 400;
    localparam logic [31:0] EMPTY = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_active = 1'b0, req_write = 1'b0, beat_go = 1'b0;
    logic [31:0] req_addr = '0, wr_data = '0;
    logic        beat_rdy, cyc_done;
    logic [31:0] rd_data, sd_dq_out;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba;
    logic [12:0] sd_a;
    logic [31:0] sd_dq_in = '0;

    int total = 0, bad = 0, model_err = 0, ref_cnt = 0, nlog = 0;
    logic [3:0]  log_c [4];
    logic [12:0] log_a [4];
    logic [31:0] mem  [int];
    logic [31:0] gold [int];
    logic [31:0] exp_q [$];
    logic [3:0]  open_v = '0;
    logic [12:0] open_row [4];
    logic [31:0] p1 = EMPTY;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] salt = 16'h1000;
    bit          prev_skip = 0;

    always #2.5 clk = ~clk;

    sdram_ctl #(.REF_INT(REF_INT)) i_sdram_ctl (
        .clk(clk), .rst_n(rst_n), .req_active(req_active), .req_write(req_write),
        .req_addr(req_addr), .beat_go(beat_go), .wr_data(wr_data),
        .beat_rdy(beat_rdy), .rd_data(rd_data), .cyc_done(cyc_done),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Device model: decodes pins, stores words, returns reads two clocks later.
    always @(posedge clk) begin
        logic [3:0] c;
        int key;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        key = int'({sd_ba, open_row[sd_ba], sd_a[7:0]});
        p1 <= EMPTY;
        sd_dq_in <= p1;
        if (rst_n) begin
            if (c != 4'b0111 && nlog < 4) begin
                log_c[nlog] = c; log_a[nlog] = sd_a; nlog++;
            end
            case (c)
                4'b0011: begin
                    if (open_v[sd_ba]) model_err++;
                    open_v[sd_ba] = 1'b1; open_row[sd_ba] = sd_a;
                end
                4'b0010: if (sd_a[10]) open_v = '0; else open_v[sd_ba] = 1'b0;
                4'b0001: begin ref_cnt++; if (open_v != '0) model_err++; end
                4'b0100: if (!open_v[sd_ba] || !sd_dq_oe) model_err++;
                         else mem[key] = sd_dq_out;
                4'b0101: if (!open_v[sd_ba]) model_err++;
                         else p1 <= mem.exists(key) ? mem[key] : EMPTY;
                default: ;
            endcase
        end
    end

    // Monitor: pops expected read words on each read beat; checks refill and done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_skip) chk(!beat_rdy, "R5", "ready after unstrobed read", 32'(beat_rdy), 0);
            prev_skip = beat_rdy && !beat_go && !req_write;
            if (beat_rdy && beat_go && !req_write) begin
                if (exp_q.size() == 0) chk(0, "R5", "read beat with nothing queued", rd_data, 0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R5", "read word", rd_data, e);
                end
            end
            if (cyc_done && req_active) chk(0, "R7", "done while active", 1, 0);
        end
    end

    function automatic bit strobe(input int pm, input int cyc);
        if (pm == 0) return 1'b1;
        if (pm == 2) return (cyc % 4) == 0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0] | lfsr[3];
    endfunction

    // Driver: one transfer of n words; queues expected read data up front.
    task automatic run_xfer(input logic [31:0] addr, input bit wr, input int n,
                            input int pm, input int lead);
        logic [22:0] base;
        int cnt, cyc, got;
        bit early_rdy;
        base = addr[24:2];
        cnt = 0; cyc = 0; early_rdy = 0;
        salt = salt + 16'h0101;
        if (!wr)
            for (int i = 0; i < n; i++) begin
                logic [22:0] k;
                k = base + 23'(i);
                exp_q.push_back(gold.exists(int'(k)) ? gold[int'(k)] : EMPTY);
            end
        @(posedge clk); #1;
        req_active = 1'b1; req_write = wr; req_addr = addr; beat_go = 1'b0;
        while (cnt < n) begin
            logic [22:0] k;
            @(posedge clk); #1;
            cyc++;
            k = base + 23'(cnt);
            beat_go = (cyc > lead) ? strobe(pm, cyc) : 1'b0;
            wr_data = {k[15:0] ^ salt, ~k[15:0]};
            @(negedge clk);
            if (cyc <= lead && beat_rdy) early_rdy = 1;
            if (beat_rdy && beat_go) begin
                if (wr) gold[int'(k)] = wr_data;
                cnt++;
            end
        end
        @(posedge clk); #1;
        req_active = 1'b0; beat_go = 1'b0;
        if (lead >= 8 && wr) chk(early_rdy, "R3", "ready waits for late first strobe", 32'(early_rdy), 1);
        got = 0;
        for (int i = 0; i < 60 && got == 0; i++) begin
            @(negedge clk);
            if (cyc_done) got = 1;
        end
        chk(got == 1, "R7", "completion pulse after request drop", got, 1);
        if (wr)
            for (int i = 0; i < n; i++) begin
                logic [22:0] k;
                k = base + 23'(i);
                chk(mem.exists(int'(k)) && mem[int'(k)] == gold[int'(k)], "R4",
                    "stored write word (R6 across rows)",
                    mem.exists(int'(k)) ? mem[int'(k)] : EMPTY, gold[int'(k)]);
            end
        else
            chk(exp_q.size() == 0, "R5", "all queued read words delivered", exp_q.size(), 0);
    endtask

    function automatic logic [31:0] wa(input int bank, input int row, input int col);
        return {7'b0, 2'(bank), 13'(row), 8'(col), 2'b00};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R3", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(beat_rdy == 1'b0, "R3", "ready low in reset", 32'(beat_rdy), 0);
        chk(cyc_done == 1'b0, "R7", "done low in reset", 32'(cyc_done), 0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R2", "NOP in reset",
            32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'h7);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (200) @(posedge clk);
        @(negedge clk);
        chk(nlog == 4, "R1", "start-up command count", nlog, 4);
        chk(log_c[0] == 4'b0010 && log_a[0][10], "R1", "first is precharge-all", 32'(log_c[0]), 32'h2);
        chk(log_c[1] == 4'b0001, "R1", "second is refresh", 32'(log_c[1]), 32'h1);
        chk(log_c[2] == 4'b0001, "R1", "third is refresh", 32'(log_c[2]), 32'h1);
        chk(log_c[3] == 4'b0000 && log_a[3] == 13'h020, "R1", "mode load",
            32'({log_c[3], log_a[3]}), 32'h0020);

        run_xfer(wa(0, 3, 10), 1, 20, 0, 0);
        run_xfer(wa(1, 5, 240), 1, 40, 1, 9);      // R6 row crossing, R3 late strobe
        run_xfer(wa(0, 8191, 250), 1, 12, 2, 0);   // R6 carry into next bank
        run_xfer(wa(0, 3, 10), 0, 20, 0, 0);
        run_xfer(wa(1, 5, 240), 0, 40, 1, 9);
        run_xfer(wa(0, 8191, 250), 0, 12, 2, 0);
        run_xfer(wa(1, 5, 236), 0, 30, 2, 3);
        run_xfer(wa(2, 20, 100), 1, 300, 1, 0);    // long: refresh at row change
        run_xfer(wa(2, 20, 100), 0, 300, 1, 0);
        run_xfer(wa(2, 21, 0), 0, 60, 0, 0);

        r0 = ref_cnt;
        repeat (3 * REF_INT) @(posedge clk);
        @(negedge clk);
        chk(ref_cnt - r0 >= 2, "R8", "idle refreshes", ref_cnt - r0, 2);
        chk(model_err == 0, "R9", "device protocol errors", model_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule